// File: doc/BRIEF.md
# Header-Directed Beam Routing Decoder

This block watches a time-division multiplexed bus that carries 128-bit subpackets from 256 uplink slots. A frame has 16 subframes, and every packet's header subpacket arrives in subframe 0, the header subframe. For each header word the block works out whether the packet carries traffic, and which destination modules should receive it. It then raises one capture enable per module: eight downlink beam modules and one onboard processor port.

The enable vector decoded for a slot in the header subframe is stored in a per-slot routing memory. The block replays that vector whenever the same slot appears in subframes 1 to 15 of the frame. Every module sees the whole bus, and only the enabled modules capture the subpacket. The enables are registered, so they lag the bus word by exactly one clock. A capturing module therefore pairs them with its own one-stage copy of the bus.

Top module: `beam_route_decoder`

## Requirements
- R1: After reset, `beamEn` is all zero.
- R2: A header word whose status nibble `busWord[127:124]` is zero marks the slot idle. `beamEn` is zero one cycle later, and it stays zero for that slot on every replay in the same frame.
- R3: A busy, non-multicast header with exactly one bit set in the destination field `busWord[104:96]` drives `beamEn` to that field one cycle later. Field bit i (0..7) enables beam i, and bit 8 enables the onboard processor.
- R4: A busy header with the multicast flag `busWord[77]` clear and several destination bits set enables only the lowest-numbered set bit.
- R5: A busy header with the multicast flag `busWord[77]` set enables every destination bit that is set, together.
- R6: On a valid word in subframes 1..15, `beamEn` one cycle later equals the vector decoded for the same slot in the current frame's header subframe.
- R7: A header subframe starts with the first valid word in subframe 0 after reset, or after a valid word in a non-zero subframe. At that point all stored routes are forgotten. A slot not decoded in the new header subframe replays zero, even if it was routed in the previous frame.
- R8: A cycle with `busValid` low gives an all-zero `beamEn` in the next cycle.
- R9: Header bits outside the status, destination and multicast fields (priority, source fields, dwell, addresses, reserved bits) have no effect on `beamEn`.
- R10: Any non-zero status value (1 to 15) marks the packet busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busWord | input | 128 | Subpacket on the bus; it holds the header in subframe 0 |
| busSlot | input | 8 | Uplink slot index of the word |
| busSubframe | input | 4 | Subframe index; 0 is the header subframe |
| busValid | input | 1 | Word strobe |
| beamEn | output | 9 | Capture enables; bits 0..7 select the beams, bit 8 the processor |

## Verification
Two functions can fall in the same cycle: forgetting the previous frame's routes and writing the first decoded route of the new frame.

The bench provokes this by opening a second frame whose first header word goes to a slot that was busy in the previous frame. Other previously busy slots are left undecoded.

The replays that follow must show the new vector for the rewritten slot and zero for every slot that was left out. This shows that the clear neither wiped the same-cycle write nor let stale routes survive.

// File: rtl/brd_pkg.sv
package brd_pkg;
  localparam int WORD_W     = 128;
  localparam int STATUS_MSB = 127;
  localparam int STATUS_LSB = 124;
  localparam int DEST_MSB   = 104;
  localparam int DEST_LSB   = 96;
  localparam int MCAST_BIT  = 77;

  // strobes from control to datapath
  typedef struct packed {
    logic hdrWrite;  // decode header and store the route
    logic replay;    // look up the stored route
    logic clearMap;  // new header subframe: forget all routes
  } brdStrobe_t;
endpackage

// File: rtl/brd_ctrl.sv
module brd_ctrl
  import brd_pkg::*;
#(
  parameter int SUBFRAMES = 16,
  localparam int SUB_W = $clog2(SUBFRAMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busValid,
  input  logic [SUB_W-1:0] busSubframe,
  output brdStrobe_t       stb
);
  logic [SUB_W-1:0] lastSub;
  logic             seenAny;
  logic             isHeader;

  assign isHeader = (busSubframe == '0);

  always_comb begin
    stb.hdrWrite = busValid && isHeader;
    stb.replay   = busValid && !isHeader;
    stb.clearMap = busValid && isHeader && (!seenAny || lastSub != '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lastSub <= '0;
      seenAny <= 1'b0;
    end else if (busValid) begin
      lastSub <= busSubframe;
      seenAny <= 1'b1;
    end
  end
endmodule

// File: rtl/brd_datapath.sv
module brd_datapath
  import brd_pkg::*;
#(
  parameter int SLOTS = 256,
  parameter int BEAMS = 8,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int DEST_W = BEAMS + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] busWord,
  input  logic [SLOT_W-1:0] busSlot,
  input  brdStrobe_t        stb,
  output logic [DEST_W-1:0] beamEn
);
  logic [3:0]        status;
  logic [DEST_W-1:0] destField;
  logic              mcast;
  logic [DEST_W-1:0] lowestBit;
  logic [DEST_W-1:0] decVec;
  logic [DEST_W-1:0] routeMem [SLOTS];
  logic [SLOTS-1:0]  validMap;
  logic              unusedBits;

  assign status    = busWord[STATUS_MSB:STATUS_LSB];
  assign destField = busWord[DEST_MSB:DEST_LSB];
  assign mcast     = busWord[MCAST_BIT];
  assign unusedBits = ^{busWord[STATUS_LSB-1:DEST_MSB+1],
                        busWord[DEST_LSB-1:MCAST_BIT+1],
                        busWord[MCAST_BIT-1:0]};

  // isolate the lowest set destination bit for point-to-point traffic
  assign lowestBit = destField & (~destField + {{(DEST_W-1){1'b0}}, 1'b1});

  always_comb begin
    if (status == 4'd0)
      decVec = '0;
    else if (mcast)
      decVec = destField;
    else
      decVec = lowestBit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      validMap <= '0;
    end else begin
      if (stb.clearMap) validMap <= '0;
      if (stb.hdrWrite) validMap[busSlot] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.hdrWrite) routeMem[busSlot] <= decVec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      beamEn <= '0;
    else if (stb.hdrWrite)
      beamEn <= decVec;
    else if (stb.replay)
      beamEn <= validMap[busSlot] ? routeMem[busSlot] : '0;
    else
      beamEn <= '0;
  end
endmodule

// File: rtl/beam_route_decoder.sv
module beam_route_decoder
  import brd_pkg::*;
#(
  parameter int SLOTS     = 256,
  parameter int SUBFRAMES = 16,
  parameter int BEAMS     = 8,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int SUB_W  = $clog2(SUBFRAMES),
  localparam int DEST_W = BEAMS + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] busWord,
  input  logic [SLOT_W-1:0] busSlot,
  input  logic [SUB_W-1:0]  busSubframe,
  input  logic              busValid,
  output logic [DEST_W-1:0] beamEn
);
  brdStrobe_t stb;

  brd_ctrl #(.SUBFRAMES(SUBFRAMES)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .busValid(busValid),
    .busSubframe(busSubframe), .stb(stb)
  );

  brd_datapath #(.SLOTS(SLOTS), .BEAMS(BEAMS)) dp_i (
    .clk(clk), .rst_n(rst_n), .busWord(busWord), .busSlot(busSlot),
    .stb(stb), .beamEn(beamEn)
  );
endmodule

// File: rtl/beam_route_decoder_chk.sv
module beam_route_decoder_chk #(
  parameter int BEAMS = 8,
  parameter int SUB_W = 4,
  localparam int DEST_W = BEAMS + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busValid,
  input logic [SUB_W-1:0]  subIdx,
  input logic [3:0]        hdrStatus,
  input logic [DEST_W-1:0] hdrDest,
  input logic              hdrMcast,
  input logic [DEST_W-1:0] beamEn
);
  AST_QUIET_WHEN_NO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    !busValid |=> beamEn == '0); // R8

  AST_IDLE_NO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busValid && subIdx == '0 && hdrStatus == 4'd0) |=> beamEn == '0); // R2

  AST_UNICAST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busValid && subIdx == '0 && !hdrMcast) |=> $onehot0(beamEn)); // R4

  AST_UNICAST_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (busValid && subIdx == '0 && hdrStatus != 4'd0 && !hdrMcast && hdrDest != '0)
      |=> ($countones(beamEn) == 1 && (beamEn & ~$past(hdrDest)) == '0)); // R3

  AST_MCAST_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (busValid && subIdx == '0 && hdrStatus != 4'd0 && hdrMcast)
      |=> beamEn == $past(hdrDest)); // R5
endmodule

bind beam_route_decoder beam_route_decoder_chk #(.BEAMS(BEAMS), .SUB_W(SUB_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .busValid(busValid), .subIdx(busSubframe),
  .hdrStatus(busWord[127:124]), .hdrDest(busWord[104:96]),
  .hdrMcast(busWord[77]), .beamEn(beamEn)
);

// File: tb/beam_route_decoder_tb_top.sv
`timescale 1ns/1ps
module beam_route_decoder_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] busWord = '0;
  logic [7:0]   busSlot = '0;
  logic [3:0]   busSubframe = '0;
  logic         busValid = 1'b0;
  logic [8:0]   beamEn;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit doneFlag = 0;

  logic [8:0] expQ[$];
  string      tagQ[$];

  logic [8:0] mdlRoute [256];
  bit         mdlValid [256];
  int         mdlLast = 0;
  bit         mdlSeen = 0;

  always #2.5 clk = ~clk;

  beam_route_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .busWord(busWord), .busSlot(busSlot),
    .busSubframe(busSubframe), .busValid(busValid), .beamEn(beamEn)
  );

  function automatic logic [127:0] mkHdr(input logic [3:0] st, input logic [8:0] dest,
                                         input logic mc, input logic [31:0] junk);
    logic [127:0] w;
    w = {junk, ~junk, junk ^ 32'h5A3C_E10F, junk + 32'h1357_9BDF};
    w[127:124] = st;
    w[104:96]  = dest;
    w[77]      = mc;
    return w;
  endfunction

  function automatic logic [8:0] expectVec(input logic [127:0] w);
    logic [8:0] d;
    d = w[104:96];
    if (w[127:124] == 4'd0) return '0;
    if (w[77]) return d;
    for (int i = 0; i < 9; i++) if (d[i]) return 9'(1) << i;
    return '0;
  endfunction

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: beamEn actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] slot, input logic [3:0] sub,
                      input logic [127:0] w, input string req);
    logic [8:0] e;
    @(negedge clk);
    busWord = w; busSlot = slot; busSubframe = sub; busValid = 1'b1;
    if (sub == 4'd0) begin
      if (!mdlSeen || mdlLast != 0) foreach (mdlValid[i]) mdlValid[i] = 0;
      e = expectVec(w);
      mdlRoute[slot] = e;
      mdlValid[slot] = 1;
    end else begin
      e = mdlValid[slot] ? mdlRoute[slot] : 9'h000;
    end
    mdlLast = int'(sub);
    mdlSeen = 1;
    expQ.push_back(e);
    tagQ.push_back(req);
  endtask

  task automatic gap(input string req);
    @(negedge clk);
    busValid = 1'b0;
    busWord = mkHdr(4'h9, 9'h1FF, 1'b1, 32'hDEAD_0001);
    expQ.push_back(9'h000);
    tagQ.push_back(req);
  endtask

  // monitor: compare after each registering edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        logic [8:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(t, beamEn, e);
      end
    end
  end

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000 && !doneFlag) begin
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    check("R1", beamEn, 9'h000);

    // frame A header subframe
    send(8'd0, 4'd0, mkHdr(4'h1, 9'h008, 1'b0, 32'h0000_0000), "R3");
    send(8'd1, 4'd0, mkHdr(4'h2, 9'h100, 1'b0, 32'h1111_2222), "R3");
    send(8'd2, 4'd0, mkHdr(4'h0, 9'h0F3, 1'b1, 32'h3333_4444), "R2");
    send(8'd3, 4'd0, mkHdr(4'h7, 9'h125, 1'b1, 32'h5555_6666), "R5");
    send(8'd4, 4'd0, mkHdr(4'h3, 9'h060, 1'b0, 32'h7777_8888), "R4");
    send(8'd5, 4'd0, mkHdr(4'hF, 9'h001, 1'b0, 32'hFFFF_FFFF), "R10");
    send(8'd6, 4'd0, mkHdr(4'h4, 9'h040, 1'b0, 32'h89AB_CDEF), "R9");
    gap("R8");
    send(8'd6, 4'd0, mkHdr(4'h4, 9'h040, 1'b0, 32'h0123_4567), "R9");

    // frame A replay subframes
    for (int s = 1; s < 16; s++) begin
      for (int k = 0; k < 8; k++) begin
        send(8'(k), 4'(s), mkHdr(4'h0, 9'h1FF, 1'b1, 32'(s * 31 + k)),
             (k == 2) ? "R2" : (k == 7) ? "R7" : "R6");
      end
      if (s == 8) gap("R8");
    end

    // frame B: clear and first write in the same cycle
    send(8'd1, 4'd0, mkHdr(4'h5, 9'h0FF, 1'b1, 32'hCAFE_0000), "R7");
    send(8'd2, 4'd0, mkHdr(4'h6, 9'h002, 1'b0, 32'hCAFE_0001), "R3");
    for (int s = 1; s < 3; s++) begin
      for (int k = 0; k < 7; k++) begin
        send(8'(k), 4'(s), mkHdr(4'h0, 9'h000, 1'b0, 32'(k)),
             (k == 1 || k == 2) ? "R6" : "R7");
      end
    end
    gap("R8");
    gap("R8");
    wait (expQ.size() == 0);
    @(negedge clk);
    doneFlag = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule